// File: doc/BRIEF.md
# Two-Rate Fourth-Order Sinc Decimator

This block turns the single-bit output of a delta-sigma modulator into 18-bit signed conversion results. Each modulator bit arrives with a one-cycle enable, at the modulator rate (76.8 kHz in the intended system). The bit is read as +1 or -1. It passes through a cascade of four integrators at the input rate and four combs at the decimated rate. That cascade gives a sinc⁴ response, in which every notch holds four coincident zeros.

A single select input picks one of two decimation ratios. The slow setting divides by 7680 and gives 10 results per second, with notches on every multiple of 10 Hz, so 50 Hz and 60 Hz are rejected together. The fast setting divides by 960 and gives 80 results per second. The comb output is scaled down by a fixed arithmetic shift per rate and saturated to the 18-bit two's complement range. Each new result is announced by a one-clock strobe.

A step at the input needs four whole conversion periods to work through the filter, so the fifth result after a restart is the first that is fully settled. A change of the rate select restarts the filter in the same way that reset does.

Top module: `sinc4_decim`

## Requirements
- R1: An input bit of 1 counts as +1 and a bit of 0 counts as -1. A steady alternating 1/0 stream therefore settles to a result of 0.
- R2: With `rate_fast` = 0, one result is produced for every 7680 accepted samples. With `rate_fast` = 1, one result is produced for every 960 accepted samples. With the enable held high, successive strobes are exactly that many clocks apart.
- R3: A sample is integrated and counted only in a cycle where `bit_en` is high. With the enable high on every other cycle, the strobes are 2×960 clocks apart at the fast rate, and the settled values are unchanged.
- R4: A settled result equals m·D⁴/2^S, where m is the stream mean (2·density−1), D is the decimation ratio, S = 22 at the fast rate and S = 34 at the slow rate. This equals 202500·m at both rates. Density 3/4 gives 18B82h, density 1/4 gives 2747Eh, and density 5/8 gives 0C5C1h.
- R5: Results above the positive limit saturate at 1FFFFh. An all-ones stream gives 1FFFFh.
- R6: Results below the negative limit saturate at 20000h, the most negative 18-bit code. An all-zeros stream gives 20000h.
- R7: After a restart, the fifth and later results are fully settled. The first result for an all-ones stream is a partial value, strictly between 0 and 1FFFFh.
- R8: A change of `rate_fast` clears all integrator and comb state and restarts the decimation count. Timing: the input sample applied in the cycle where `rate_fast` changes is discarded, and the first strobe at the new rate appears D+1 clocks after the change (enable held high). That first result is again partial.
- R9: During reset, `res_valid` is 0 and `res_data` is 0. After reset is released, with the enable held high, the first strobe appears D clocks later.
- R10: `res_valid` is high for exactly one clock per result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` as a new modulator sample |
| bit_in | input | 1 | Modulator bit: 1 means +1, 0 means -1 |
| rate_fast | input | 1 | 0 selects decimation by 7680, 1 selects decimation by 960 |
| res_data | output | 18 | Latest result, two's complement, saturated |
| res_valid | output | 1 | One-clock strobe marking a new result |

## Verification
The embedded properties assume that `rate_fast` and `bit_en` are synchronous to `clk` and stable at the clock edge. They also assume that reset is held for at least one edge before the first sample. Saturation and strobe properties further rely on the decimation ratio being at least 2, so that two ticks never fall on adjacent cycles. The stimulus changes every input only on the falling edge. It uses periodic bit patterns whose period divides both ratios, so each settled result has an exact closed-form value. Rate changes are applied while the enable is high, which makes the restart latency fixed and predictable.

// File: rtl/sinc4_pkg.sv
package sinc4_pkg;
  // number of integrator and comb stages
  localparam int unsigned ORDER = 4;

  // maps a modulator bit onto a signed unit step
  function automatic logic signed [1:0] bit_to_step(input logic b);
    return b ? 2'sb01 : 2'sb11;
  endfunction
endpackage

// File: rtl/sinc4_rate_ctl.sv
module sinc4_rate_ctl #(
  parameter int unsigned SLOW_DECIM = 7680,
  parameter int unsigned FAST_DECIM = 960,
  localparam int unsigned CNT_W = $clog2(SLOW_DECIM)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rate_fast,
  output logic clr,
  output logic tick,
  output logic fast_sel
);
  logic             rate_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign clr      = (rate_fast != rate_q);
  assign fast_sel = rate_q;
  assign last     = rate_q ? CNT_W'(FAST_DECIM - 1) : CNT_W'(SLOW_DECIM - 1);
  assign tick     = en && !clr && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= rate_fast;
      cnt    <= '0;
    end else if (clr) begin
      rate_q <= rate_fast;
      cnt    <= '0;
    end else if (en) begin
      cnt <= (cnt == last) ? '0 : cnt + 1'b1;
    end
  end

  // R2: the count never reaches the selected ratio
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= last);
  // R8: a rate change restarts the count
  a_r8_cnt_restart: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
  // R3: without an enable the count holds
  a_r3_cnt_holds: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/sinc4_integ.sv
module sinc4_integ
  import sinc4_pkg::*;
#(
  parameter int unsigned ACC_W = 53
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    en,
  input  logic                    bit_in,
  output logic signed [ACC_W-1:0] acc_out
);
  logic signed [ACC_W-1:0] acc [ORDER];
  logic signed [ACC_W-1:0] unit;

  assign unit    = ACC_W'(bit_to_step(bit_in));
  assign acc_out = acc[ORDER-1];

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    logic signed [ACC_W-1:0] addend;
    if (k == 0) begin : g_head
      assign addend = unit;
    end else begin : g_chain
      assign addend = acc[k-1];
    end
    // modular wrap is intended: the combs cancel it
    always_ff @(posedge clk) begin
      if (rst || clr)  acc[k] <= '0;
      else if (en)     acc[k] <= acc[k] + addend;
    end
  end

  // R1: the first integrator moves by +1 for a one and -1 for a zero
  a_r1_unit_step: assert property (@(posedge clk) disable iff (rst)
    (en && !clr) |=> ($past(bit_in) ? (acc[0] == $past(acc[0]) + 1)
                                    : (acc[0] == $past(acc[0]) - 1)));
  // R8: a clear empties the integrators
  a_r8_integ_cleared: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc[0] == '0 && acc[ORDER-1] == '0));
endmodule

// File: rtl/sinc4_comb.sv
module sinc4_comb
  import sinc4_pkg::*;
#(
  parameter int unsigned ACC_W = 53
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    tick,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] dout
);
  logic signed [ACC_W-1:0] diff [ORDER+1];
  logic signed [ACC_W-1:0] dly  [ORDER];

  assign diff[0] = din;
  assign dout    = diff[ORDER];

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    assign diff[k+1] = diff[k] - dly[k];
    always_ff @(posedge clk) begin
      if (rst || clr) dly[k] <= '0;
      else if (tick)  dly[k] <= diff[k];
    end
  end

  // R8: a clear empties the comb delays
  a_r8_comb_cleared: assert property (@(posedge clk) disable iff (rst)
    clr |=> (dly[0] == '0 && dly[ORDER-1] == '0));
endmodule

// File: rtl/sinc4_outfmt.sv
module sinc4_outfmt #(
  parameter int unsigned ACC_W      = 53,
  parameter int unsigned OUT_W      = 18,
  parameter int unsigned SLOW_SHIFT = 34,
  parameter int unsigned FAST_SHIFT = 22
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    fast_sel,
  input  logic signed [ACC_W-1:0] comb_in,
  output logic [OUT_W-1:0]        res_data,
  output logic                    res_valid
);
  localparam logic signed [ACC_W-1:0] POS_LIM =
    {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] NEG_LIM =
    {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [ACC_W-1:0] scaled;
  logic signed [ACC_W-1:0] clipped;
  logic                    over_hi;
  logic                    over_lo;

  assign scaled  = fast_sel ? (comb_in >>> FAST_SHIFT) : (comb_in >>> SLOW_SHIFT);
  assign over_hi = scaled > POS_LIM;
  assign over_lo = scaled < NEG_LIM;

  always_comb begin
    if (over_hi)      clipped = POS_LIM;
    else if (over_lo) clipped = NEG_LIM;
    else              clipped = scaled;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data  <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= tick;
      if (tick) res_data <= clipped[OUT_W-1:0];
    end
  end

  // R10: the strobe lasts a single clock
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  // R5: overrange above clips to the top code
  a_r5_clip_high: assert property (@(posedge clk) disable iff (rst)
    (tick && comb_in > (POS_LIM <<< (fast_sel ? FAST_SHIFT : SLOW_SHIFT)) + 64'sd0)
      |=> (res_data == {1'b0, {(OUT_W-1){1'b1}}}));
  // R6: overrange below clips to the bottom code
  a_r6_clip_low: assert property (@(posedge clk) disable iff (rst)
    (tick && comb_in[ACC_W-1] && over_lo) |=> (res_data == {1'b1, {(OUT_W-1){1'b0}}}));
  // R9: a strobe follows a decimation tick
  a_r9_valid_after_tick: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(tick));
endmodule

// File: rtl/sinc4_decim.sv
module sinc4_decim #(
  parameter int unsigned SLOW_DECIM = 7680,
  parameter int unsigned FAST_DECIM = 960,
  parameter int unsigned SLOW_SHIFT = 34,
  parameter int unsigned FAST_SHIFT = 22,
  parameter int unsigned OUT_W      = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             rate_fast,
  output logic [OUT_W-1:0] res_data,
  output logic             res_valid
);
  import sinc4_pkg::*;

  localparam int unsigned ACC_W = ORDER * $clog2(SLOW_DECIM) + 1;

  logic                    clr;
  logic                    tick;
  logic                    fast_sel;
  logic signed [ACC_W-1:0] integ_out;
  logic signed [ACC_W-1:0] comb_out;

  sinc4_rate_ctl #(
    .SLOW_DECIM(SLOW_DECIM),
    .FAST_DECIM(FAST_DECIM)
  ) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .en       (bit_en),
    .rate_fast(rate_fast),
    .clr      (clr),
    .tick     (tick),
    .fast_sel (fast_sel)
  );

  sinc4_integ #(.ACC_W(ACC_W)) u_integ (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .en     (bit_en),
    .bit_in (bit_in),
    .acc_out(integ_out)
  );

  sinc4_comb #(.ACC_W(ACC_W)) u_comb (
    .clk (clk),
    .rst (rst),
    .clr (clr),
    .tick(tick),
    .din (integ_out),
    .dout(comb_out)
  );

  sinc4_outfmt #(
    .ACC_W     (ACC_W),
    .OUT_W     (OUT_W),
    .SLOW_SHIFT(SLOW_SHIFT),
    .FAST_SHIFT(FAST_SHIFT)
  ) u_fmt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .fast_sel (fast_sel),
    .comb_in  (comb_out),
    .res_data (res_data),
    .res_valid(res_valid)
  );
endmodule

// File: tb/sinc4_decim_bench.sv
module sinc4_decim_bench;
  localparam int FAST_D = 960;
  localparam int SLOW_D = 7680;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic        bit_in = 1'b0;
  logic        rate_fast = 1'b1;
  logic [17:0] res_data;
  logic        res_valid;

  sinc4_decim u_sinc4_decim (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .rate_fast(rate_fast), .res_data(res_data), .res_valid(res_valid)
  );

  always #5 clk = ~clk;

  int total = 0;
  int fails = 0;
  int cyc   = 0;
  logic [7:0]  pat = 8'hFF;
  int          ph = 0;
  logic        half_en = 1'b0;
  logic        seen = 1'b0;
  logic [17:0] got = '0;

  // {rate_fast, pattern (bit 0 first), expected settled result}
  localparam logic [26:0] VEC [7] = '{
    {1'b1, 8'hEE, 18'h18B82},
    {1'b1, 8'h11, 18'h2747E},
    {1'b1, 8'h55, 18'h00000},
    {1'b1, 8'hFF, 18'h1FFFF},
    {1'b1, 8'h00, 18'h20000},
    {1'b1, 8'h6D, 18'h0C5C1},
    {1'b0, 8'hEE, 18'h18B82}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive();
    bit_en = half_en ? ~bit_en : 1'b1;
    bit_in = pat[ph];
    if (bit_en) ph = (ph + 1) % 8;
  endtask

  task automatic step();
    @(negedge clk);
    seen = res_valid;
    got  = res_data;
    drive();
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst = 1'b1;
    bit_en = 1'b0;
    repeat (3) @(negedge clk);
    // R9: idle outputs while reset is held
    chk(res_valid == 1'b0 && res_data == 18'h0, "R9 reset state",
        int'({res_valid, res_data}), 0);
    rst = 1'b0;
    ph = 0;
    bit_en = 1'b0;
    drive();
  endtask

  task automatic wait_result(output int n);
    n = 0;
    seen = 1'b0;
    while (!seen && n < 20000) begin
      step();
      n++;
    end
    if (!seen) chk(1'b0, "R10 strobe missing", n, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      total++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=<190000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int n;
    // vector walk: settled values and periods per rate
    foreach (VEC[i]) begin
      int    dr;
      string tag;
      rate_fast = VEC[i][26];
      pat       = VEC[i][25:18];
      half_en   = 1'b0;
      dr        = VEC[i][26] ? FAST_D : SLOW_D;
      if (VEC[i][17:0] == 18'h1FFFF)      tag = "R5 clip high";
      else if (VEC[i][17:0] == 18'h20000) tag = "R6 clip low";
      else if (VEC[i][17:0] == 18'h0)     tag = "R1 sign map";
      else                                tag = "R4 scaling";
      reset_dut();
      wait_result(n);
      chk(n == dr, "R9 first strobe after reset", n, dr);
      for (int j = 2; j <= 4; j++) wait_result(n);
      wait_result(n);
      chk(got == VEC[i][17:0], {tag, " R7 fifth result"}, int'(got), int'(VEC[i][17:0]));
      wait_result(n);
      chk(n == dr, "R2 strobe period", n, dr);
      chk(got == VEC[i][17:0], tag, int'(got), int'(VEC[i][17:0]));
    end

    // R7: partial first result, then R10 pulse width
    rate_fast = 1'b1;
    pat = 8'hFF;
    half_en = 1'b0;
    reset_dut();
    wait_result(n);
    chk(got != 18'h0 && got[17] == 1'b0 && got != 18'h1FFFF, "R7 partial first", int'(got), 1);
    step();
    chk(seen == 1'b0, "R10 strobe one clock", int'(seen), 0);
    wait_result(n);
    chk(n == FAST_D - 1, "R10 next strobe", n, FAST_D - 1);
    for (int j = 3; j <= 5; j++) wait_result(n);
    chk(got == 18'h1FFFF, "R5 settled all ones", int'(got), 18'h1FFFF);

    // R8: rate change clears state and restarts the count
    @(negedge clk);
    rate_fast = 1'b0;
    drive();
    wait_result(n);
    chk(n == SLOW_D + 1, "R8 restart latency to slow", n, SLOW_D + 1);
    chk(got != 18'h0 && got[17] == 1'b0 && got != 18'h1FFFF, "R8 partial after change",
        int'(got), 1);
    @(negedge clk);
    rate_fast = 1'b1;
    drive();
    wait_result(n);
    chk(n == FAST_D + 1, "R8 restart latency to fast", n, FAST_D + 1);

    // R3: enable on every other cycle
    rate_fast = 1'b1;
    pat = 8'hEE;
    half_en = 1'b1;
    reset_dut();
    wait_result(n);
    chk(n == 2 * FAST_D - 1, "R3 first strobe with half enable", n, 2 * FAST_D - 1);
    for (int j = 2; j <= 5; j++) wait_result(n);
    chk(n == 2 * FAST_D, "R3 strobe period with half enable", n, 2 * FAST_D);
    chk(got == 18'h18B82, "R3 settled value with half enable", int'(got), 18'h18B82);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule